// File: doc/BRIEF.md
# Indirect LPC I/O Cycle Master

This block lets a host reach byte-wide I/O ports behind a Low Pin Count bus without ever driving the bus itself. The host programs a small register window over a simple 32-bit register bus. It sets how many byte cycles to run, whether they are reads or writes, and the first port address. For writes it also queues the outgoing bytes. A write to the launch register then hands the whole burst to the block, and the block turns it into back-to-back LPC I/O cycles on a 4-bit multiplexed bus with a frame strobe.

During a burst the block steps through the cycles one after another. Each cycle either moves to the next port address or stays on the same port, which suits streaming into a single data port. Target wait syncs stretch a cycle. A target that stalls for too long, or that answers with an error sync, ends the whole burst early. Bytes read back collect in a queue that the host drains one register read at a time. A status register reports idle and success. A sticky completion flag, cleared by writing one to it, can drive an interrupt line.

The LPC side runs on the same clock as the register bus. The bidirectional data lines are split into an input, an output and an output enable, so the pad belongs to the level above this block.

Top module: `lpc_io_master`

## Requirements
- R1: After reset the status register (offset 0x04) reads 0x1 (bit0 idle set, bit1 success clear), offset 0x08 reads 0, `irq` is low, `lframe_n` is high and `lad_oe` is low.
- R2: Writing a value with bit0 set to offset 0x00 while idle starts a burst of N byte cycles, where N is the value of the length register (offset 0x10, bits 4:0). A length of 0 completes at once with success and no bus activity, and lengths above 16 run 16 cycles.
- R3: A write cycle drives, one clock each, `lframe_n` low with LAD=0000, then 0010, then the four port address nibbles most significant first, then the data byte low nibble before high nibble, then 1111 for one clock with the output enabled, after which the block releases the bus until the cycle ends.
- R4: A read cycle drives 0000 in the direction slot and releases the bus after the address. After the ready sync it samples the low data nibble and then the high nibble. Each byte is pushed to the read queue, and successive reads of offset 0x28 return the bytes in cycle order; a read of the empty queue returns 0.
- R5: Command register (offset 0x14) bit3 set makes every cycle of the burst use the programmed address; bit3 clear adds one to the address on each cycle. Bit0 selects write (1) or read (0).
- R6: Writes to offset 0x24 queue their low byte (up to 16); write cycles consume queued bytes in order, and a write cycle with an empty queue sends 0x00.
- R7: During the sync slot any nibble other than 0000 (ready) or 1010 (error) counts as a wait; a cycle with up to 256 wait clocks still completes normally.
- R8: A 257th wait clock or an error sync aborts the burst: no further cycles run, the status reads 0x1 and the unsent write bytes are discarded.
- R9: While a burst runs the status reads 0x0; a burst that ends normally leaves it at 0x3.
- R10: Offset 0x08 bit0 is an interrupt enable and bit1 a completion flag set at the end of every burst (success, abort or refused start). Writing 1 to bit1 clears it. `irq` equals enable AND flag.
- R11: While a burst runs, writes to offsets 0x10, 0x14, 0x20, 0x24 and further starts are ignored.
- R12: A start with command bits 2:1 not zero (a non-I/O cycle type) runs no cycle and ends at once with status 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register bus and the LPC bus |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one clock per access |
| reg_rd | input | 1 | Register read strobe, one clock per access |
| reg_ofs | input | 6 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the clock after `reg_rd` |
| irq | output | 1 | Completion interrupt, enable AND flag |
| lad_in | input | 4 | LPC data lines as seen at the pad |
| lad_out | output | 4 | LPC data driven by the block |
| lad_oe | output | 1 | Output enable for `lad_out` |
| lframe_n | output | 1 | Active-low frame strobe, low on the start nibble |

## Verification
The bench runs a target model next to the bus. The model decodes every frame, logs direction, address and data, and answers with a chosen number of wait syncs, ready or error. It covers exactly 256 waits against 257, an error sync in the middle of a write burst, lengths 0 and 20, and same-port against incrementing bursts. A design that counts waits off by one, or keeps running after an abort, shows up as an extra or missing logged cycle or a wrong status. It also probes register writes and a second start while a burst is busy. It then pops the read queue past empty and sends a write burst with no queued bytes after an abort. A design that leaks a stale byte or accepts a busy-time write therefore puts a visible wrong value on the bus or in the read data.

// File: rtl/lpc_pkg.sv
// Shared constants and state types for the indirect LPC I/O master.
// Assumes a 6-bit byte offset on the register bus and 4-bit LPC nibbles.
package lpc_pkg;

    localparam int REG_OFS_W = 6;

    // Register offsets decoded by host software.
    localparam logic [REG_OFS_W-1:0] OFS_GO   = 6'h00;
    localparam logic [REG_OFS_W-1:0] OFS_STAT = 6'h04;
    localparam logic [REG_OFS_W-1:0] OFS_IRQ  = 6'h08;
    localparam logic [REG_OFS_W-1:0] OFS_LEN  = 6'h10;
    localparam logic [REG_OFS_W-1:0] OFS_CMD  = 6'h14;
    localparam logic [REG_OFS_W-1:0] OFS_ADDR = 6'h20;
    localparam logic [REG_OFS_W-1:0] OFS_WDAT = 6'h24;
    localparam logic [REG_OFS_W-1:0] OFS_RDAT = 6'h28;

    // Command word fields.
    localparam int CMD_WR_BIT   = 0;
    localparam int CMD_TYPE_LO  = 1;
    localparam int CMD_TYPE_HI  = 2;
    localparam int CMD_SAME_BIT = 3;
    localparam int CMD_W        = 4;

    // LPC nibble codes.
    localparam logic [3:0] NIB_START  = 4'b0000;
    localparam logic [3:0] NIB_IO_RD  = 4'b0000;
    localparam logic [3:0] NIB_IO_WR  = 4'b0010;
    localparam logic [3:0] NIB_TAR    = 4'b1111;
    localparam logic [3:0] SYNC_READY = 4'b0000;
    localparam logic [3:0] SYNC_ERROR = 4'b1010;

    // Per-cycle bus phases.
    typedef enum logic [3:0] {
        PH_IDLE, PH_START, PH_DIR, PH_ADDR, PH_WDATA,
        PH_TAR0, PH_TAR1, PH_SYNC, PH_RDATA, PH_END0, PH_END1
    } phase_t;

    // Burst sequencer states.
    typedef enum logic [1:0] {
        SQ_IDLE, SQ_LAUNCH, SQ_WAIT
    } seq_t;

endpackage

// File: rtl/lpc_byte_fifo.sv
// Byte queue with show-ahead head, synchronous flush and drop-on-full push.
// Assumes DEPTH is a power of two; a pop on empty is ignored.
module lpc_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr_q];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr_q] <= push_data;
    end

    assert_fifo_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    assert_fifo_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !flush) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/lpc_cycle_engine.sv
// Runs one LPC I/O byte cycle per go pulse: start, direction, address,
// optional write data, turnaround, sync with wait counting, optional read
// data, closing turnaround. Ends with a one-clock done or fail pulse.
// Assumes go is only raised while busy is low.
module lpc_cycle_engine
    import lpc_pkg::*;
#(
    parameter int PORT_W   = 16,
    parameter int MAX_WAIT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_write,
    input  logic [PORT_W-1:0] go_addr,
    input  logic [7:0]        go_wdata,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    output logic              lframe_n,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [7:0]        rdata
);
    localparam int NIBS   = PORT_W / 4;
    localparam int NIB_W  = (NIBS > 2) ? $clog2(NIBS) : 1;
    localparam int WCNT_W = $clog2(MAX_WAIT + 1);
    localparam logic [NIB_W-1:0]  LAST_ADDR_NIB = NIB_W'(NIBS - 1);
    localparam logic [NIB_W-1:0]  LAST_DATA_NIB = NIB_W'(1);
    localparam logic [WCNT_W-1:0] WAIT_LIMIT    = WCNT_W'(MAX_WAIT);

    phase_t             ph_q;
    logic               wr_q;
    logic [PORT_W-1:0]  addr_sh_q;
    logic [7:0]         wdat_sh_q;
    logic [7:0]         rdat_q;
    logic [NIB_W-1:0]   nib_q;
    logic [WCNT_W-1:0]  wait_q;

    // Phase sequencing, shifters and sync handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q      <= PH_IDLE;
            wr_q      <= 1'b0;
            addr_sh_q <= '0;
            wdat_sh_q <= '0;
            rdat_q    <= '0;
            nib_q     <= '0;
            wait_q    <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            case (ph_q)
                PH_IDLE: if (go) begin
                    wr_q      <= go_write;
                    addr_sh_q <= go_addr;
                    wdat_sh_q <= go_wdata;
                    ph_q      <= PH_START;
                end
                PH_START: ph_q <= PH_DIR;
                PH_DIR: begin
                    nib_q <= '0;
                    ph_q  <= PH_ADDR;
                end
                PH_ADDR: begin
                    addr_sh_q <= addr_sh_q << 4;
                    nib_q     <= nib_q + 1'b1;
                    if (nib_q == LAST_ADDR_NIB) begin
                        nib_q <= '0;
                        ph_q  <= wr_q ? PH_WDATA : PH_TAR0;
                    end
                end
                PH_WDATA: begin
                    wdat_sh_q <= wdat_sh_q >> 4;
                    nib_q     <= nib_q + 1'b1;
                    if (nib_q == LAST_DATA_NIB) ph_q <= PH_TAR0;
                end
                PH_TAR0: ph_q <= PH_TAR1;
                PH_TAR1: begin
                    wait_q <= '0;
                    ph_q   <= PH_SYNC;
                end
                PH_SYNC: begin
                    if (lad_in == SYNC_READY) begin
                        nib_q <= '0;
                        ph_q  <= wr_q ? PH_END0 : PH_RDATA;
                    end else if (lad_in == SYNC_ERROR || wait_q == WAIT_LIMIT) begin
                        fail <= 1'b1;
                        ph_q <= PH_IDLE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                PH_RDATA: begin
                    rdat_q <= {lad_in, rdat_q[7:4]};
                    nib_q  <= nib_q + 1'b1;
                    if (nib_q == LAST_DATA_NIB) ph_q <= PH_END0;
                end
                PH_END0: ph_q <= PH_END1;
                PH_END1: begin
                    done <= 1'b1;
                    ph_q <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Bus drive per phase.
    always_comb begin
        lad_out = NIB_TAR;
        lad_oe  = 1'b0;
        case (ph_q)
            PH_START: begin lad_out = NIB_START; lad_oe = 1'b1; end
            PH_DIR:   begin lad_out = wr_q ? NIB_IO_WR : NIB_IO_RD; lad_oe = 1'b1; end
            PH_ADDR:  begin lad_out = addr_sh_q[PORT_W-1 -: 4]; lad_oe = 1'b1; end
            PH_WDATA: begin lad_out = wdat_sh_q[3:0]; lad_oe = 1'b1; end
            PH_TAR0:  begin lad_out = NIB_TAR; lad_oe = 1'b1; end
            default:  begin lad_out = NIB_TAR; lad_oe = 1'b0; end
        endcase
    end

    assign lframe_n = (ph_q != PH_START);
    assign busy     = (ph_q != PH_IDLE);
    assign rdata    = rdat_q;

    assert_frame_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |=> lframe_n);

    assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q <= WAIT_LIMIT);

    assert_end_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    assert_go_idle_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

endmodule

// File: rtl/lpc_io_master.sv
// Register-programmed master that runs bursts of byte-wide LPC I/O cycles.
// Holds the host register window, the write and read byte queues and the
// burst sequencer; one lpc_cycle_engine does the bus work per byte.
// Assumes PORT_W < DATA_W and queues at least MAX_BURST deep.
module lpc_io_master
    import lpc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PORT_W    = 16,
    parameter int MAX_BURST = 16,
    parameter int QDEPTH    = 16,
    parameter int MAX_WAIT  = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [REG_OFS_W-1:0] reg_ofs,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq,
    input  logic [3:0]           lad_in,
    output logic [3:0]           lad_out,
    output logic                 lad_oe,
    output logic                 lframe_n
);
    localparam int LEN_W = $clog2(MAX_BURST + 1);
    localparam logic [LEN_W-1:0] BURST_CAP = LEN_W'(MAX_BURST);

    logic [LEN_W-1:0]  len_q, left_q, eff_len;
    logic [CMD_W-1:0]  cmd_q;
    logic [PORT_W-1:0] addr_q, cur_addr_q;
    logic              run_wr_q, run_same_q;
    logic              fin_q, irq_en_q, irq_st_q;
    seq_t              seq_q;

    logic              cfg_wr, go_hit, type_bad, burst_end;
    logic              eng_go, eng_busy, eng_done, eng_fail;
    logic [7:0]        eng_rdata, eng_wdata;
    logic              wq_push, wq_pop, wq_empty, wq_full;
    logic              rq_push, rq_pop, rq_empty, rq_full, rq_flush;
    logic [7:0]        wq_head, rq_head;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:PORT_W];

    // Decode of host strokes and burst end events.
    always_comb begin
        cfg_wr    = reg_wr && (seq_q == SQ_IDLE);
        go_hit    = cfg_wr && (reg_ofs == OFS_GO) && reg_wdata[0];
        type_bad  = (cmd_q[CMD_TYPE_HI:CMD_TYPE_LO] != 2'b00);
        eff_len   = (len_q > BURST_CAP) ? BURST_CAP : len_q;
        burst_end = (go_hit && (type_bad || eff_len == '0)) ||
                    ((seq_q == SQ_WAIT) &&
                     (eng_fail || (eng_done && left_q == LEN_W'(1))));
    end

    // Burst configuration registers, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
        end else if (cfg_wr) begin
            if (reg_ofs == OFS_LEN)  len_q  <= reg_wdata[LEN_W-1:0];
            if (reg_ofs == OFS_CMD)  cmd_q  <= reg_wdata[CMD_W-1:0];
            if (reg_ofs == OFS_ADDR) addr_q <= reg_wdata[PORT_W-1:0];
        end
    end

    // Burst sequencer: launches one engine cycle per byte and tracks result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q      <= SQ_IDLE;
            left_q     <= '0;
            cur_addr_q <= '0;
            run_wr_q   <= 1'b0;
            run_same_q <= 1'b0;
            fin_q      <= 1'b0;
        end else begin
            case (seq_q)
                SQ_IDLE: if (go_hit) begin
                    if (type_bad) begin
                        fin_q <= 1'b0;
                    end else if (eff_len == '0) begin
                        fin_q <= 1'b1;
                    end else begin
                        fin_q      <= 1'b0;
                        left_q     <= eff_len;
                        cur_addr_q <= addr_q;
                        run_wr_q   <= cmd_q[CMD_WR_BIT];
                        run_same_q <= cmd_q[CMD_SAME_BIT];
                        seq_q      <= SQ_LAUNCH;
                    end
                end
                SQ_LAUNCH: seq_q <= SQ_WAIT;
                SQ_WAIT: begin
                    if (eng_fail) begin
                        seq_q <= SQ_IDLE;
                        fin_q <= 1'b0;
                    end else if (eng_done) begin
                        left_q <= left_q - 1'b1;
                        if (!run_same_q) cur_addr_q <= cur_addr_q + 1'b1;
                        if (left_q == LEN_W'(1)) begin
                            seq_q <= SQ_IDLE;
                            fin_q <= 1'b1;
                        end else begin
                            seq_q <= SQ_LAUNCH;
                        end
                    end
                end
                default: seq_q <= SQ_IDLE;
            endcase
        end
    end

    // Interrupt enable and sticky completion flag (write one to clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            irq_st_q <= 1'b0;
        end else begin
            if (reg_wr && reg_ofs == OFS_IRQ) irq_en_q <= reg_wdata[0];
            if (burst_end)
                irq_st_q <= 1'b1;
            else if (reg_wr && reg_ofs == OFS_IRQ && reg_wdata[1])
                irq_st_q <= 1'b0;
        end
    end

    assign irq = irq_en_q && irq_st_q;

    // Queue and engine hookup.
    assign eng_go    = (seq_q == SQ_LAUNCH);
    assign eng_wdata = wq_empty ? 8'h00 : wq_head;
    assign wq_push   = cfg_wr && (reg_ofs == OFS_WDAT);
    assign wq_pop    = eng_go && run_wr_q;
    assign rq_push   = (seq_q == SQ_WAIT) && eng_done && !run_wr_q;
    assign rq_pop    = reg_rd && (reg_ofs == OFS_RDAT);
    assign rq_flush  = go_hit && !type_bad && (eff_len != '0);

    lpc_byte_fifo #(.W(8), .DEPTH(QDEPTH)) u_wq (
        .clk(clk), .rst_n(rst_n), .flush(eng_fail),
        .push(wq_push), .push_data(reg_wdata[7:0]), .pop(wq_pop),
        .head(wq_head), .empty(wq_empty), .full(wq_full)
    );

    lpc_byte_fifo #(.W(8), .DEPTH(QDEPTH)) u_rq (
        .clk(clk), .rst_n(rst_n), .flush(rq_flush),
        .push(rq_push && !rq_full), .push_data(eng_rdata), .pop(rq_pop),
        .head(rq_head), .empty(rq_empty), .full(rq_full)
    );

    lpc_cycle_engine #(.PORT_W(PORT_W), .MAX_WAIT(MAX_WAIT)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .go_write(run_wr_q),
        .go_addr(cur_addr_q), .go_wdata(eng_wdata), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .lframe_n(lframe_n),
        .busy(eng_busy), .done(eng_done), .fail(eng_fail), .rdata(eng_rdata)
    );

    // Registered read port; a read of the data queue pops it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_ofs)
                OFS_STAT: reg_rdata <= DATA_W'({fin_q, seq_q == SQ_IDLE});
                OFS_IRQ:  reg_rdata <= DATA_W'({irq_st_q, irq_en_q});
                OFS_LEN:  reg_rdata <= DATA_W'(len_q);
                OFS_CMD:  reg_rdata <= DATA_W'(cmd_q);
                OFS_ADDR: reg_rdata <= DATA_W'(addr_q);
                OFS_RDAT: reg_rdata <= rq_empty ? '0 : DATA_W'(rq_head);
                default:  reg_rdata <= '0;
            endcase
        end
    end

    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q != SQ_IDLE && reg_wr && reg_ofs == OFS_LEN) |=> $stable(len_q));

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q == SQ_WAIT && eng_fail) |=> (seq_q == SQ_IDLE && !fin_q));

    assert_end_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |=> irq_st_q);

    assert_bad_type_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (go_hit && type_bad) |=> (seq_q == SQ_IDLE && !eng_busy));

endmodule

// File: tb/tb_lpc_io_master.sv
`timescale 1ns/1ps
module tb_lpc_io_master;

    localparam logic [5:0] A_GO = 6'h00, A_STAT = 6'h04, A_IRQ = 6'h08, A_LEN = 6'h10,
                           A_CMD = 6'h14, A_ADDR = 6'h20, A_WDAT = 6'h24, A_RDAT = 6'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_ofs = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe, lframe_n;

    int checks = 0, errors = 0;
    bit finished = 0;

    // target model knobs and log
    int          tw_waits = 0;
    int          t_err_at = -1;
    int          t_long_at = -1;
    logic [3:0]  rec_dir  [256];
    logic [15:0] rec_addr [256];
    logic [7:0]  rec_data [256];
    int          rec_n = 0;
    int          fights = 0, tar_bad = 0;
    logic [7:0]  tx [16];

    always #2.5 clk = ~clk;

    lpc_io_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_ofs(reg_ofs),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .lframe_n(lframe_n)
    );

    function automatic logic [7:0] tgt_byte(input logic [15:0] a, input int idx);
        return a[7:0] ^ 8'(idx * 37 + 11);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] o, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_ofs = o; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] o, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_ofs = o;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(A_STAT, v);
            if (v[0]) break;
        end
    endtask

    // Target model: decodes frames at the falling edge and answers sync/data.
    task automatic target_model();
        int ph = 0, sub = 0, wl = 0, k = 0, idx = 0;
        bit w = 0;
        logic [3:0] dir = '0, fin = '0;
        logic [15:0] a = '0;
        logic [7:0] d = '0, rb = '0;
        forever begin
            @(negedge clk);
            if (!lframe_n && lad_oe && lad_out == 4'h0) begin
                ph = 0; sub = 1; lad_in = 4'hF;
            end else if (sub == 1) begin
                ph++;
                if (ph == 1) begin dir = lad_out; w = (lad_out == 4'h2); end
                else if (ph <= 5) a = {a[11:0], lad_out};
                else if (w && ph == 6) d[3:0] = lad_out;
                else if (w && ph == 7) d[7:4] = lad_out;
                if (ph == (w ? 8 : 6) && !(lad_oe && lad_out == 4'hF)) tar_bad++;
                if (ph == (w ? 9 : 7)) begin
                    idx = rec_n;
                    rec_dir[idx] = dir; rec_addr[idx] = a; rec_data[idx] = w ? d : 8'h00;
                    rec_n++;
                    wl  = (idx == t_long_at) ? 257 : tw_waits;
                    fin = (idx == t_err_at) ? 4'hA : 4'h0;
                    rb  = tgt_byte(a, idx);
                    sub = 2;
                end
            end else if (sub == 2) begin
                if (lad_oe) fights++;
                if (wl > 0) begin lad_in = 4'h6; wl--; end
                else begin
                    lad_in = fin; k = 0;
                    sub = (fin == 4'h0 && !w) ? 3 : 4;
                end
            end else if (sub == 3) begin
                if (lad_oe) fights++;
                lad_in = (k == 0) ? rb[3:0] : rb[7:4];
                k++;
                if (k == 2) sub = 4;
            end else if (sub == 4) begin
                lad_in = 4'hF; sub = 0;
            end
        end
    endtask

    initial target_model();

    // Program, launch and fully check one burst that must end successfully.
    task automatic run_burst(input bit w, input bit same, input int len,
                             input logic [15:0] a, input string tag);
        int n = (len > 16) ? 16 : len;
        int base = rec_n;
        logic [31:0] v;
        logic [15:0] ea;
        wr(A_LEN, 32'(len));
        wr(A_CMD, {28'd0, same, 2'b00, w});
        wr(A_ADDR, {16'd0, a});
        if (w) for (int i = 0; i < n; i++) wr(A_WDAT, {24'd0, tx[i]});
        wr(A_GO, 32'd1);
        wait_idle();
        rd(A_STAT, v);
        check({tag, " R9 status"}, v, 32'h3);
        check({tag, " R2 cycle count"}, 32'(rec_n - base), 32'(n));
        for (int j = 0; j < n; j++) begin
            ea = same ? a : a + 16'(j);
            check({tag, " R5 addr"}, {16'd0, rec_addr[base + j]}, {16'd0, ea});
            check({tag, " R3 dir"}, {28'd0, rec_dir[base + j]}, w ? 32'h2 : 32'h0);
            if (w) check({tag, " R6 wdata"}, {24'd0, rec_data[base + j]}, {24'd0, tx[j]});
        end
        if (!w) begin
            for (int j = 0; j < n; j++) begin
                ea = same ? a : a + 16'(j);
                rd(A_RDAT, v);
                check({tag, " R4 rdata"}, v, {24'd0, tgt_byte(ea, base + j)});
            end
            rd(A_RDAT, v);
            check({tag, " R4 empty pop"}, v, 32'h0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int base;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 lframe_n", {31'd0, lframe_n}, 32'h1);
        check("R1 lad_oe", {31'd0, lad_oe}, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        rd(A_STAT, v); check("R1 status", v, 32'h1);
        rd(A_IRQ, v);  check("R1 irq reg", v, 32'h0);

        // R10 enable interrupt, R3/R6 write burst incrementing
        wr(A_IRQ, 32'h1);
        for (int i = 0; i < 16; i++) tx[i] = 8'hA0 + 8'(i * 7);
        run_burst(1'b1, 1'b0, 4, 16'h0080, "wr-inc");
        check("R10 irq after burst", {31'd0, irq}, 32'h1);
        rd(A_IRQ, v); check("R10 irq reg set", v, 32'h3);
        wr(A_IRQ, 32'h3);
        rd(A_IRQ, v); check("R10 w1c", v, 32'h1);
        check("R10 irq cleared", {31'd0, irq}, 32'h0);
        check("R3 turnaround", 32'(tar_bad), 32'h0);

        // R4/R5 read same address
        run_burst(1'b0, 1'b1, 3, 16'h02F8, "rd-same");
        // R5 write same address
        run_burst(1'b1, 1'b1, 5, 16'h0CA2, "wr-same");

        // R7 exactly 256 waits passes
        tw_waits = 256;
        run_burst(1'b0, 1'b0, 1, 16'h0060, "R7 wait256");
        tw_waits = 0;

        // R8 257 waits aborts
        base = rec_n; t_long_at = base;
        wr(A_LEN, 32'd2); wr(A_CMD, 32'h0); wr(A_ADDR, 32'h0064);
        wr(A_GO, 32'd1); wait_idle();
        rd(A_STAT, v); check("R8 timeout status", v, 32'h1);
        check("R8 timeout cycles", 32'(rec_n - base), 32'd1);
        t_long_at = -1;

        // R8 error sync mid write burst, queue discarded
        base = rec_n; t_err_at = base + 1;
        wr(A_LEN, 32'd4); wr(A_CMD, 32'h1); wr(A_ADDR, 32'h0300);
        for (int i = 0; i < 4; i++) wr(A_WDAT, 32'h11 * (i + 1));
        wr(A_GO, 32'd1); wait_idle();
        rd(A_STAT, v); check("R8 error status", v, 32'h1);
        check("R8 error cycles", 32'(rec_n - base), 32'd2);
        t_err_at = -1;
        base = rec_n;
        wr(A_LEN, 32'd1); wr(A_GO, 32'd1); wait_idle();
        check("R8 queue flushed", {24'd0, rec_data[base]}, 32'h0);
        check("R6 empty queue sends zero", 32'(rec_n - base), 32'd1);

        // R11 writes while busy ignored, R9 busy status
        tw_waits = 20; base = rec_n;
        wr(A_LEN, 32'd8); wr(A_CMD, 32'h0); wr(A_ADDR, 32'h0400);
        wr(A_GO, 32'd1);
        rd(A_STAT, v); check("R9 busy status", v, 32'h0);
        wr(A_LEN, 32'd2); wr(A_CMD, 32'h1); wr(A_ADDR, 32'h1234);
        wr(A_WDAT, 32'h77); wr(A_GO, 32'd1);
        wait_idle();
        tw_waits = 0;
        check("R11 cycles", 32'(rec_n - base), 32'd8);
        check("R11 last addr", {16'd0, rec_addr[base + 7]}, 32'h0407);
        rd(A_LEN, v);  check("R11 len kept", v, 32'd8);
        rd(A_CMD, v);  check("R11 cmd kept", v, 32'h0);
        rd(A_ADDR, v); check("R11 addr kept", v, 32'h0400);
        base = rec_n;
        wr(A_LEN, 32'd1); wr(A_CMD, 32'h1); wr(A_GO, 32'd1); wait_idle();
        check("R11 wdata dropped", {24'd0, rec_data[base]}, 32'h0);

        // R2 length 0 and clamp
        base = rec_n;
        wr(A_LEN, 32'd0); wr(A_GO, 32'd1); wait_idle();
        rd(A_STAT, v); check("R2 len0 status", v, 32'h3);
        check("R2 len0 no cycles", 32'(rec_n - base), 32'd0);
        run_burst(1'b0, 1'b0, 20, 16'h0500, "R2 clamp");

        // R12 non-I/O cycle type refused
        base = rec_n;
        wr(A_IRQ, 32'h3);
        wr(A_LEN, 32'd3); wr(A_CMD, 32'h4); wr(A_GO, 32'd1); wait_idle();
        rd(A_STAT, v); check("R12 status", v, 32'h1);
        check("R12 no cycles", 32'(rec_n - base), 32'd0);
        check("R12 irq", {31'd0, irq}, 32'h1);

        // random bursts
        for (int it = 0; it < 8; it++) begin
            tw_waits = int'($urandom % 6);
            for (int i = 0; i < 16; i++) tx[i] = 8'($urandom);
            run_burst(1'($urandom), 1'($urandom), 1 + int'($urandom % 16),
                      16'($urandom), "rand");
        end
        check("R4 bus fights", 32'(fights), 32'h0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule